// File: doc/BRIEF.md
# Register Rename Map and Free List

This block renames one instruction per cycle. Each instruction names two source registers and, optionally, one destination register, all drawn from a small set of architectural names. A name is only a label. The block keeps a larger pool of physical registers, so several versions of one name can be live at the same time. A map table records, for every architectural name, which physical register holds its newest value. A free list holds the physical registers that are not in use.

For each accepted instruction, the block looks up both sources in the map table. If the instruction writes a destination, the block takes the oldest entry from the free list and points that destination's map entry at it. The renamed tags appear on registered outputs one cycle later. Write-after-read and write-after-write conflicts disappear, because every write gets a fresh location. Read-after-write links are kept, because a later reader finds the newest writer's tag.

When the free list is empty, a request is refused through a combinational stall and no state changes. A separate release port hands a physical register back to the free list. Later stages use it once a value is dead.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register k maps to physical register k. The free list then holds physical registers ARCH_REGS to PHYS_REGS-1, lowest first. With no request, out_valid is 0 and stall is 0.
- R2: Destinations are allocated in ascending order from the reset free list. With 8 names and 16 registers, the first allocations are p8, p9, p10 and so on.
- R3: Both source lookups use the mapping that held before the instruction's own destination update. An instruction that reads and writes the same name gets the old tag on its source.
- R4: A source name returns the tag allocated to the most recent accepted instruction that wrote that name (read-after-write is kept).
- R5: An instruction with dst_en = 0 allocates nothing and leaves the map unchanged. It drives out_dst_en = 0, and the next allocation continues the sequence.
- R6: A request made while the free list is empty drives stall = 1 in the same cycle. It is not accepted (out_valid = 0 in the next cycle), and it changes neither the map nor the free list.
- R7: A released tag joins the free list behind the tags already there, and tags are handed out first-in first-out.
- R8: Outputs are registered. out_valid is 1 exactly in the cycle after an accepted request, and the tags are valid with it.
- R9: A release and an allocation in the same cycle both take effect: the allocation uses the old head, and the released tag is kept for a later allocation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Rename request this cycle |
| src_a | input | AW | First source architectural name |
| src_b | input | AW | Second source architectural name |
| dst_en | input | 1 | Instruction writes a destination |
| dst | input | AW | Destination architectural name |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_tag | input | PW | Physical register being returned |
| stall | output | 1 | Request refused: free list empty |
| out_valid | output | 1 | Renamed instruction valid (registered) |
| out_src_a | output | PW | Physical tag of first source |
| out_src_b | output | PW | Physical tag of second source |
| out_dst_en | output | 1 | Renamed instruction has a destination |
| out_dst | output | PW | Newly allocated destination tag |

## Verification
The assertions assume the release port is used correctly. A tag is released only when it is neither in the free list nor mapped, and never the tag allocated in the previous cycle. Under that assumption the free-list count never passes the pool size, and back-to-back destinations always differ. The stimulus keeps to this: it releases only tags that were displaced from the map or are otherwise idle, and it does so only after the free list has been drained. Each physical register therefore has at most one owner at any time.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned ARCH_REGS_DEF = 8;
  localparam int unsigned PHYS_REGS_DEF = 16;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PHYS_REGS = 16,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  output logic [PW-1:0] tag_a,
  output logic [PW-1:0] tag_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_tag
);
  logic [PW-1:0] slot [ARCH_REGS];

  // reads see the state before this cycle's write
  assign tag_a = slot[rd_a];
  assign tag_b = slot[rd_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) slot[i] <= PW'(i);
    end else if (wr_en) begin
      slot[wr_idx] <= wr_tag;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PHYS_REGS = 16,
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned CW = $clog2(PHYS_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [PW-1:0] head_tag,
  output logic [CW-1:0] count
);
  logic [PW-1:0] ring [PHYS_REGS];
  logic [PW-1:0] head, tail;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(PHYS_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_tag = ring[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS_REGS; i++) ring[i] <= PW'((i + ARCH_REGS) % PHYS_REGS);
      head  <= '0;
      tail  <= PW'(PHYS_REGS - ARCH_REGS);
      count <= CW'(PHYS_REGS - ARCH_REGS);
    end else begin
      if (push) begin
        ring[tail] <= push_tag;
        tail       <= bump(tail);
      end
      if (pop) head <= bump(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int unsigned ARCH_REGS = rn_pkg::ARCH_REGS_DEF,
  parameter int unsigned PHYS_REGS = rn_pkg::PHYS_REGS_DEF,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned CW = $clog2(PHYS_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          dst_en,
  input  logic [AW-1:0] dst,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag,
  output logic          stall,
  output logic          out_valid,
  output logic [PW-1:0] out_src_a,
  output logic [PW-1:0] out_src_b,
  output logic          out_dst_en,
  output logic [PW-1:0] out_dst
);
  logic [CW-1:0] fl_count;
  logic [PW-1:0] fl_head, map_a, map_b;
  logic          fl_empty, accept, alloc;

  assign fl_empty = (fl_count == '0);
  assign stall    = req_valid && fl_empty;
  assign accept   = req_valid && !fl_empty;
  assign alloc    = accept && dst_en;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk(clk), .rst(rst),
    .rd_a(src_a), .rd_b(src_b), .tag_a(map_a), .tag_b(map_b),
    .wr_en(alloc), .wr_idx(dst), .wr_tag(fl_head)
  );

  rn_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rst(rst),
    .pop(alloc), .push(rel_valid), .push_tag(rel_tag),
    .head_tag(fl_head), .count(fl_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_src_a  <= '0;
      out_src_b  <= '0;
      out_dst_en <= 1'b0;
      out_dst    <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src_a  <= map_a;
        out_src_b  <= map_b;
        out_dst_en <= dst_en;
        out_dst    <= dst_en ? fl_head : '0;
      end
    end
  end
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PHYS_REGS = 16,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned CW = $clog2(PHYS_REGS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] src_a,
  input logic          dst_en,
  input logic [AW-1:0] dst,
  input logic          rel_valid,
  input logic          stall,
  input logic          out_valid,
  input logic [PW-1:0] out_src_a,
  input logic          out_dst_en,
  input logic [PW-1:0] out_dst,
  input logic [CW-1:0] fl_count
);
  logic took;
  assign took = req_valid && !stall;

  p_refused_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> !out_valid);

  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (stall && !rel_valid) |=> (fl_count == '0));

  p_registered_r8: assert property (@(posedge clk) disable iff (rst)
    took |=> out_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    fl_count <= CW'(PHYS_REGS));

  p_fresh_dst_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dst_en && $past(out_valid && out_dst_en)) |-> (out_dst != $past(out_dst)));

  p_raw_kept_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(took) && $past(took, 2) && $past(dst_en, 2) && ($past(src_a) == $past(dst, 2)))
      |-> (out_src_a == $past(out_dst)));
endmodule

bind rename_unit rename_unit_chk #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .src_a(src_a), .dst_en(dst_en),
  .dst(dst), .rel_valid(rel_valid), .stall(stall), .out_valid(out_valid),
  .out_src_a(out_src_a), .out_dst_en(out_dst_en), .out_dst(out_dst),
  .fl_count(fl_count)
);

// File: tb/rename_unit_test.sv
module rename_unit_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, dst_en, rel_valid;
  logic [2:0] src_a, src_b, dst;
  logic [3:0] rel_tag;
  logic       stall, out_valid, out_dst_en;
  logic [3:0] out_src_a, out_src_b, out_dst;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  rename_unit #(.ARCH_REGS(8), .PHYS_REGS(16)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .src_a(src_a), .src_b(src_b),
    .dst_en(dst_en), .dst(dst), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .stall(stall), .out_valid(out_valid), .out_src_a(out_src_a),
    .out_src_b(out_src_b), .out_dst_en(out_dst_en), .out_dst(out_dst)
  );

  // fields: sa[3] sb[3] de[1] d[3] exp_a[4] exp_b[4] exp_d[4]
  localparam logic [21:0] VEC [9] = '{
    {3'd1, 3'd2, 1'b1, 3'd3, 4'd1,  4'd2,  4'd8 },  // R1 identity, R2 first alloc
    {3'd3, 3'd3, 1'b1, 3'd3, 4'd8,  4'd8,  4'd9 },  // R3 src==dst reads old
    {3'd3, 3'd0, 1'b1, 3'd5, 4'd9,  4'd0,  4'd10},  // R4
    {3'd5, 3'd3, 1'b0, 3'd0, 4'd10, 4'd9,  4'd0 },  // R5 no destination
    {3'd5, 3'd7, 1'b1, 3'd0, 4'd10, 4'd7,  4'd11},  // R5 sequence continues
    {3'd0, 3'd4, 1'b1, 3'd7, 4'd11, 4'd4,  4'd12},
    {3'd7, 3'd6, 1'b1, 3'd7, 4'd12, 4'd6,  4'd13},
    {3'd7, 3'd7, 1'b1, 3'd1, 4'd13, 4'd13, 4'd14},
    {3'd1, 3'd3, 1'b1, 3'd2, 4'd14, 4'd9,  4'd15}   // drains free list
  };

  task automatic chk(input string rq, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  // drive after negedge, check stall before the edge, outputs 2 ns after it
  task automatic step(input logic rv, input logic [2:0] sa, input logic [2:0] sb,
                      input logic de, input logic [2:0] d,
                      input logic lv, input logic [3:0] lt,
                      input int exp_stall, input int exp_valid,
                      input int ea, input int eb, input int ed, input string rq);
    req_valid = rv; src_a = sa; src_b = sb; dst_en = de; dst = d;
    rel_valid = lv; rel_tag = lt;
    #1;
    if (rv) chk({rq, " stall"}, int'(stall), exp_stall);
    @(posedge clk); #2;
    chk({rq, " out_valid"}, int'(out_valid), exp_valid);
    if (exp_valid == 1) begin
      chk({rq, " src_a"}, int'(out_src_a), ea);
      chk({rq, " src_b"}, int'(out_src_b), eb);
      chk({rq, " dst_en"}, int'(out_dst_en), int'(de));
      if (de) chk({rq, " dst"}, int'(out_dst), ed);
    end
    @(negedge clk);
    req_valid = 1'b0; rel_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; dst_en = 1'b0; rel_valid = 1'b0;
    src_a = '0; src_b = '0; dst = '0; rel_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset stall", int'(stall), 0);

    for (int i = 0; i < 9; i++) begin
      step(1'b1, VEC[i][21:19], VEC[i][18:16], VEC[i][15], VEC[i][14:12],
           1'b0, 4'd0, 0, 1,
           int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]), "R2/R3/R4/R5 vector");
    end

    // free list now empty: request refused, no state touched
    step(1'b1, 3'd2, 3'd3, 1'b1, 3'd4, 1'b0, 4'd0, 1, 0, 0, 0, 0, "R6 empty stall");
    // releases with no request: nothing emitted
    step(1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd3, 0, 0, 0, 0, 0, "R8 idle");
    step(1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd5, 0, 0, 0, 0, 0, "R8 idle");
    // r4 still maps to p4 (stalled write dropped); p3 comes out first
    step(1'b1, 3'd4, 3'd2, 1'b1, 3'd4, 1'b0, 4'd0, 0, 1, 4, 15, 3, "R6 R7 fifo");
    // allocate and release together
    step(1'b1, 3'd4, 3'd0, 1'b1, 3'd6, 1'b1, 4'd2, 0, 1, 3, 11, 5, "R9 concurrent");
    step(1'b1, 3'd6, 3'd1, 1'b1, 3'd1, 1'b0, 4'd0, 0, 1, 5, 14, 2, "R9 released kept");
    // empty again
    step(1'b1, 3'd1, 3'd1, 1'b0, 3'd0, 1'b0, 4'd0, 1, 0, 0, 0, 0, "R6 empty again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule